// File: doc/BRIEF.md
# Imprecise Data-Fault NMI Capture Unit

This block sits between the data-side memory interface and the trap controller of a processor. Four single-cycle fault pulses report errors that show up after the faulting load or store has retired: a load bus error, a store bus error, a load integrity (parity/checksum) error and a store integrity error. The unit keeps the first such event, turns it into a non-maskable interrupt request and holds the matching cause word until the trap controller reports that the handler has been entered.

Only one fault is held at a time. Faults that arrive while one is pending are dropped. The latch accepts a new fault again in the cycle the acknowledge arrives. The request ignores the global interrupt enable completely. It is held back only while the core is in debug mode, or while it single-steps with the step-interrupt enable cleared. A fault held during that time is shown as soon as the masking condition ends. A pending flag for the debug status register shows the held state whether or not the request is masked.

Top module: `nmi_capture_unit`

## Requirements
- R1: After reset, `nmi_pend_o` is 0, `nmi_req_o` is 0 and `nmi_cause_o` is all zeros.
- R2: A fault that is latched sets `nmi_cause_o` to bit 31 set (interrupt flag) plus a code in bits 30:0. The codes are: load bus error 1024 (0x80000400), store bus error 1025 (0x80000401), load integrity error 1026 (0x80000402), store integrity error 1027 (0x80000403).
- R3: When several fault inputs are high in the same cycle and the latch is accepting, the code with the highest value wins. The order is store integrity, then load integrity, then store bus, then load bus.
- R4: While `nmi_pend_o` is 1 and `nmi_ack_i` is 0, every fault input is ignored: `nmi_cause_o` and `nmi_pend_o` keep their values.
- R5: `nmi_ack_i` while pending, with no fault input high, clears `nmi_pend_o` at the next edge. `nmi_cause_o` keeps the last latched word.
- R6: A fault in the same cycle as `nmi_ack_i` is latched as a new pending NMI with its own code.
- R7: A fault pulse sampled at a clock edge makes `nmi_pend_o` 1 right after that edge. When the request is not masked, `nmi_req_o` is also 1 right after that edge. The block has no global interrupt enable input, so that enable cannot mask the request.
- R8: While `dbg_mode_i` is 1, `nmi_req_o` is 0 and `nmi_pend_o` still reflects the held fault. The request appears in the same cycle `dbg_mode_i` returns to 0.
- R9: While `step_on_i` is 1 and `step_irq_en_i` is 0, `nmi_req_o` is 0. With `step_irq_en_i` at 1, stepping does not mask the request.
- R10: `nmi_ack_i` with nothing pending and no fault input high has no effect: `nmi_pend_o` stays 0 and `nmi_cause_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flt_ld_bus_i | input | 1 | Load bus error pulse |
| flt_st_bus_i | input | 1 | Store bus error pulse |
| flt_ld_chk_i | input | 1 | Load integrity error pulse |
| flt_st_chk_i | input | 1 | Store integrity error pulse |
| dbg_mode_i | input | 1 | Core is in debug mode |
| step_on_i | input | 1 | Single-step is active |
| step_irq_en_i | input | 1 | Interrupts allowed while stepping |
| nmi_ack_i | input | 1 | Trap controller has entered the NMI handler |
| nmi_req_o | output | 1 | NMI request to the trap controller |
| nmi_pend_o | output | 1 | NMI pending flag for the debug status register |
| nmi_cause_o | output | 32 | Latched cause word |

## Verification
The properties assume that the trap controller raises `nmi_ack_i` only in a cycle where `nmi_req_o` is high. Under that assumption the acknowledge never meets an empty latch unless the fault and the acknowledge arrive together. The bench follows this rule everywhere except in one deliberate case for R10. In that case it acknowledges with nothing pending and looks only at the port values. All mask combinations are set up between clock edges and held while faults are injected, so each masking check sees a steady mask for a whole cycle.

// File: rtl/nmi_cap_pkg.sv
package nmi_cap_pkg;
   // number of data-side fault sources, index order is also priority order
   localparam int unsigned NMI_SRC_N     = 4;
   localparam int unsigned NMI_IDX_W     = $clog2(NMI_SRC_N);
   localparam int unsigned NMI_CODE_BASE = 1024;
   localparam int unsigned NMI_CAUSE_W   = 32;

   // index of each source inside the fault vector
   localparam int unsigned SRC_LD_BUS = 0;
   localparam int unsigned SRC_ST_BUS = 1;
   localparam int unsigned SRC_LD_CHK = 2;
   localparam int unsigned SRC_ST_CHK = 3;
endpackage

// File: rtl/nmi_fault_prio.sv
module nmi_fault_prio #(
   parameter int unsigned N_SRC = 4,
   localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_SRC-1:0] src_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   logic [N_SRC-1:0] above;
   logic [N_SRC-1:0] win;

   if (N_SRC < 2) begin : g_chk_src
      $error("nmi_fault_prio: N_SRC must be at least 2");
   end

   // highest index has nothing above it
   assign above[N_SRC-1] = 1'b0;
   for (genvar i = N_SRC - 2; i >= 0; i--) begin : g_above
      assign above[i] = above[i+1] | src_i[i+1];
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_win
      assign win[i] = src_i[i] & ~above[i];
   end

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (win[i]) idx_o = idx_o | IDX_W'(i);
      end
   end

   assign any_o = |win;

   // R3: exactly one winner whenever any source is active
   p_single_winner_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|src_i) |-> ($countones(win) == 1));
   // R3: the winner is the highest active source
   p_winner_top_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_o |-> ((src_i >> idx_o) >> 1) == '0);
endmodule

// File: rtl/nmi_cause_latch.sv
module nmi_cause_latch #(
   parameter int unsigned CAUSE_W = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               load_any_i,
   input  logic [CAUSE_W-1:0] load_cause_i,
   input  logic               ack_i,
   output logic               pend_o,
   output logic [CAUSE_W-1:0] cause_o
);
   logic accept;

   if (CAUSE_W < 12) begin : g_chk_w
      $error("nmi_cause_latch: CAUSE_W too narrow for codes 1024..1027");
   end

   // latch accepts when empty or when the handler is being entered
   assign accept = !pend_o || ack_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_o  <= 1'b0;
         cause_o <= '0;
      end else if (accept) begin
         if (load_any_i) begin
            pend_o  <= 1'b1;
            cause_o <= load_cause_i;
         end else begin
            pend_o  <= 1'b0;
         end
      end
   end

   // R4: a held fault is not overwritten
   p_first_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o && !ack_i) |=> (pend_o && $stable(cause_o)));
   // R5: acknowledge without a new fault empties the latch
   p_ack_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o && ack_i && !load_any_i) |=> (!pend_o && $stable(cause_o)));
   // R6: a fault meeting an open latch is captured
   p_rearm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_any_i && (!pend_o || ack_i)) |=> (pend_o && cause_o == $past(load_cause_i)));
   // R10: an idle acknowledge changes nothing
   p_idle_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pend_o && !load_any_i) |=> (!pend_o && $stable(cause_o)));
endmodule

// File: rtl/nmi_req_mask.sv
module nmi_req_mask (
   input  logic pend_i,
   input  logic dbg_mode_i,
   input  logic step_on_i,
   input  logic step_irq_en_i,
   output logic req_o
);
   logic blocked;

   assign blocked = dbg_mode_i | (step_on_i & ~step_irq_en_i);
   assign req_o   = pend_i & ~blocked;
endmodule

// File: rtl/nmi_capture_unit.sv
module nmi_capture_unit
   import nmi_cap_pkg::*;
(
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   flt_ld_bus_i,
   input  logic                   flt_st_bus_i,
   input  logic                   flt_ld_chk_i,
   input  logic                   flt_st_chk_i,
   input  logic                   dbg_mode_i,
   input  logic                   step_on_i,
   input  logic                   step_irq_en_i,
   input  logic                   nmi_ack_i,
   output logic                   nmi_req_o,
   output logic                   nmi_pend_o,
   output logic [NMI_CAUSE_W-1:0] nmi_cause_o
);
   logic [NMI_SRC_N-1:0]   flt_vec;
   logic                   flt_any;
   logic [NMI_IDX_W-1:0]   flt_idx;
   logic [NMI_CAUSE_W-1:0] flt_cause;

   if (NMI_CODE_BASE + NMI_SRC_N > (1 << (NMI_CAUSE_W - 1))) begin : g_chk_code
      $error("nmi_capture_unit: codes do not fit below the interrupt flag");
   end

   always_comb begin
      flt_vec             = '0;
      flt_vec[SRC_LD_BUS] = flt_ld_bus_i;
      flt_vec[SRC_ST_BUS] = flt_st_bus_i;
      flt_vec[SRC_LD_CHK] = flt_ld_chk_i;
      flt_vec[SRC_ST_CHK] = flt_st_chk_i;
   end

   nmi_fault_prio #(.N_SRC(NMI_SRC_N)) u_prio (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .src_i (flt_vec),
      .any_o (flt_any),
      .idx_o (flt_idx)
   );

   assign flt_cause = {1'b1, {(NMI_CAUSE_W-1){1'b0}}}
                    | NMI_CAUSE_W'(NMI_CODE_BASE)
                    | NMI_CAUSE_W'(flt_idx);

   nmi_cause_latch #(.CAUSE_W(NMI_CAUSE_W)) u_latch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_any_i  (flt_any),
      .load_cause_i(flt_cause),
      .ack_i       (nmi_ack_i),
      .pend_o      (nmi_pend_o),
      .cause_o     (nmi_cause_o)
   );

   nmi_req_mask u_mask (
      .pend_i       (nmi_pend_o),
      .dbg_mode_i   (dbg_mode_i),
      .step_on_i    (step_on_i),
      .step_irq_en_i(step_irq_en_i),
      .req_o        (nmi_req_o)
   );

   // R7: a request always stands on a held fault
   p_req_needs_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nmi_req_o |-> nmi_pend_o);
   // R8: debug mode hides the request
   p_dbg_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dbg_mode_i |-> !nmi_req_o);
   // R9: stepping without interrupt permission hides the request
   p_step_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_on_i && !step_irq_en_i) |-> !nmi_req_o);
   // R2: a held cause always carries the flag and a code in range
   p_cause_form_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nmi_pend_o |-> (nmi_cause_o[NMI_CAUSE_W-1]
                      && nmi_cause_o[NMI_CAUSE_W-2:0] >= (NMI_CAUSE_W-1)'(NMI_CODE_BASE)
                      && nmi_cause_o[NMI_CAUSE_W-2:0] <  (NMI_CAUSE_W-1)'(NMI_CODE_BASE + NMI_SRC_N)));
endmodule

// File: tb/nmi_capture_unit_bench.sv
`timescale 1ns/1ps
module nmi_capture_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  flt = '0;   // {st_chk, ld_chk, st_bus, ld_bus}
   logic        dbg = 1'b0, step = 1'b0, step_en = 1'b0, ack = 1'b0;
   logic        req, pend;
   logic [31:0] cause;
   int          n_chk = 0, n_bad = 0;
   logic        done = 1'b0;

   always #2.5 clk = ~clk;

   nmi_capture_unit u_nmi_capture_unit (
      .clk_i(clk), .rst_ni(rst_n),
      .flt_ld_bus_i(flt[0]), .flt_st_bus_i(flt[1]),
      .flt_ld_chk_i(flt[2]), .flt_st_chk_i(flt[3]),
      .dbg_mode_i(dbg), .step_on_i(step), .step_irq_en_i(step_en),
      .nmi_ack_i(ack),
      .nmi_req_o(req), .nmi_pend_o(pend), .nmi_cause_o(cause)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [31:0] exp_cause(input logic [3:0] v);
      logic [31:0] c = 32'h0;
      for (int i = 0; i < 4; i++) if (v[i]) c = 32'h8000_0000 + 32'd1024 + 32'(i);
      return c;
   endfunction

   task automatic pulse(input logic [3:0] v);
      flt = v; tick(); flt = '0;
   endtask

   task automatic do_ack();
      ack = 1'b1; tick(); ack = 1'b0;
   endtask

   initial begin
      logic [31:0] held;
      #1;
      chk("R1 pend", 32'(pend), 0);
      chk("R1 req", 32'(req), 0);
      chk("R1 cause", cause, 0);
      rst_n = 1'b1;
      tick();
      chk("R1 pend after release", 32'(pend), 0);

      // R2 R3 R7: every non-empty fault combination from an empty latch
      for (int v = 1; v < 16; v++) begin
         pulse(4'(v));
         chk("R7 pend", 32'(pend), 1);
         chk("R7 req", 32'(req), 1);
         chk("R3 cause", cause, exp_cause(4'(v)));
         do_ack();
         chk("R5 cleared", 32'(pend), 0);
         chk("R5 cause kept", cause, exp_cause(4'(v)));
      end

      // R4: first single fault, then every later combination is dropped
      for (int f = 0; f < 4; f++) begin
         pulse(4'(1 << f));
         for (int v = 1; v < 16; v++) begin
            pulse(4'(v));
            chk("R4 cause held", cause, exp_cause(4'(1 << f)));
            chk("R4 pend held", 32'(pend), 1);
         end
         // R6: fault together with acknowledge
         flt = 4'((1 << ((f + 1) % 4))); ack = 1'b1; tick(); flt = '0; ack = 1'b0;
         chk("R6 pend", 32'(pend), 1);
         chk("R6 cause", cause, exp_cause(4'(1 << ((f + 1) % 4))));
         do_ack();
         chk("R5 cleared", 32'(pend), 0);
      end

      // R10: idle acknowledge
      held = cause;
      do_ack();
      chk("R10 pend", 32'(pend), 0);
      chk("R10 cause", cause, held);

      // R8 R9: sweep all mask input combinations
      for (int m = 0; m < 8; m++) begin
         logic exp_req;
         dbg = m[0]; step = m[1]; step_en = m[2];
         exp_req = !(m[0] || (m[1] && !m[2]));
         pulse(4'b0010);
         chk("R8 R9 pend under mask", 32'(pend), 1);
         chk("R8 R9 req", 32'(req), 32'(exp_req));
         tick(); tick();
         chk("R8 R9 req steady", 32'(req), 32'(exp_req));
         dbg = 1'b0; step = 1'b0; #1;
         chk("R8 release same cycle", 32'(req), 1);
         do_ack();
         chk("R5 cleared", 32'(pend), 0);
      end

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule